// File: doc/BRIEF.md
# Register-Programmed Serial Flash Command Sequencer

This block runs one serial flash transaction that software describes in a small register set. Software loads an opcode/dummy word, an address word, four outbound data words and a configuration word. It then sets the execute bit in the control/status register. The sequencer walks a fixed list of phases: an optional opcode byte, zero to four address bytes, up to 31 outbound bytes, a dummy phase and up to 31 inbound bytes. Each item goes to a downstream shifter over a request/acknowledge handshake that also carries the item's width in bits.

Outbound data bytes are taken from the four data-out words, and every byte past the sixteenth comes from the last word. Dummy bytes come from the upper three bytes of the opcode word, and the top byte repeats. Each dummy byte is sent as bit groups of 1, 2, 4 or 8 bits. Inbound bytes fill four data-in words, and bytes beyond them are clocked through and dropped. A software-selected chip select can be driven for the length of the transaction. When the transaction ends, a sticky ready bit is set and the execute bit drops.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: Register indices are: 0 config, 1 control/status, 2 opcode word, 3 address, 4..7 data-out words 0..3, 8..11 data-in words 0..3. After reset they read config 0x00000400, control/status 0x00010000, opcode word 0x0000000B and all others 0. After reset all chip selects are high and no transfer is requested.
- R2: Phases run in the order opcode, address, write data, dummy, read data. The opcode byte is opcode word bits [7:0] and is sent only when config bit 10 is 1. Every item outside the dummy phase is sent with a width of 8 bits, and a requested item holds its data and width until it is acknowledged.
- R3: Config bits [13:11] give the number of address bytes, and they are sent most significant first. Four bytes start with address bits [31:24], three with [23:16], two with [15:8], and one sends [7:0]. The values 0, 5, 6 and 7 send no address.
- R4: Config bits [20:16] give the number of write bytes. Byte i comes from data-out word i/4 when i<16, and from data-out word 3 when i>=16. In both cases it is taken at lane i%4, where lane 0 is bits [7:0].
- R5: Config bits [23:21] give the number of dummy bytes, and config bits [7:6] hold a code c. Each dummy byte is sent as 8>>c groups of 1<<c bits, lowest bits first, with each group in the low bits of the transfer data. Dummy byte 0 uses opcode word bits [15:8], byte 1 uses [23:16], and every later byte uses [31:24].
- R6: Config bits [28:24] give the number of read bytes. Byte i is stored into data-in word i/4 at lane i%4 for i<16. Later bytes are transferred but stored nowhere.
- R7: Writing 1 to control/status bit 0 while idle starts a transaction, and bit 0 reads 1 until the transaction ends and 0 afterwards. At the end, bit 24 (ready) becomes 1. Writing 1 to bit 24 clears it, and this can be done in the same write that starts a new transaction.
- R8: When control/status bit 16 is 1 at the start, the chip select numbered by bits [9:8] is driven low for every transfer of the transaction and released at its end. When bit 16 is 0, all chip selects stay high.
- R9: When the chip select number is at or above NUM_CS, no chip select is driven low, and the transaction still runs in full.
- R10: Register writes made while a transaction runs are ignored, and writes to the data-in words are always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| xfer_req | output | 1 | An item is waiting for the shifter |
| xfer_data | output | 8 | Outbound item, right-aligned |
| xfer_bits | output | 4 | Item width: 1, 2, 4 or 8 bits |
| xfer_ack | input | 1 | Shifter has taken the current item |
| xfer_rdata | input | 8 | Byte received with the acknowledged item |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Clearing the sticky ready bit and starting a new transaction can happen in the same control/status write. The bench provokes this by writing both bits at once after a completed transaction. It judges the result by reading the register on the next cycle, where ready must be 0 and execute 1, and by seeing ready return to 1 only after the last inbound byte. A second collision the bench targets is a register write that lands while the sequencer waits on an unacknowledged item. The bench judges it by the opcode actually sent and by reading back the unchanged register.

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer #(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              xfer_req,
  output logic [7:0]        xfer_data,
  output logic [3:0]        xfer_bits,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rdata,
  output logic [NUM_CS-1:0] cs_n
);

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADR, PH_WR, PH_DUM, PH_RD, PH_END} phase_t;

  phase_t      phase;
  logic [31:0] cfg, cmd, adr;
  logic [31:0] dout [4];
  logic [31:0] din  [4];
  logic [1:0]  dev, cs_sel;
  logic        swcs, ready, busy, cs_act;
  logic [5:0]  cnt;
  logic [2:0]  grp;
  logic [5:0]  plen;
  logic [7:0]  dsrc;

  wire [1:0] code    = cfg[7:6];
  wire [2:0] alen    = (cfg[13:11] > 3'd4) ? 3'd0 : cfg[13:11];
  wire [3:0] gw      = 4'd1 << code;
  wire [2:0] glast   = 3'((4'd8 >> code) - 4'd1);
  wire [2:0] gshift  = grp << code;
  wire [7:0] gmask   = 8'hFF >> (4'd8 - gw);
  wire [1:0] abyte   = 2'(alen - 3'd1 - cnt[2:0]);
  wire [1:0] wword   = cnt[4] ? 2'd3 : cnt[3:2];
  wire       in_xfer = (phase != PH_IDLE) && (phase != PH_END);
  wire       ph_done = (cnt == plen);
  wire       take    = xfer_req && xfer_ack;

  always_comb begin
    case (phase)
      PH_OPC:  plen = {5'd0, cfg[10]};
      PH_ADR:  plen = {3'd0, alen};
      PH_WR:   plen = {1'b0, cfg[20:16]};
      PH_DUM:  plen = {3'd0, cfg[23:21]};
      PH_RD:   plen = {1'b0, cfg[28:24]};
      default: plen = 6'd0;
    endcase
  end

  always_comb begin
    if (cnt == 6'd0)      dsrc = cmd[15:8];
    else if (cnt == 6'd1) dsrc = cmd[23:16];
    else                  dsrc = cmd[31:24];
  end

  assign xfer_req  = in_xfer && !ph_done;
  assign xfer_bits = (phase == PH_DUM) ? gw : 4'd8;

  always_comb begin
    case (phase)
      PH_OPC:  xfer_data = cmd[7:0];
      PH_ADR:  xfer_data = adr[{abyte, 3'b000} +: 8];
      PH_WR:   xfer_data = dout[wword][{cnt[1:0], 3'b000} +: 8];
      PH_DUM:  xfer_data = (dsrc >> gshift) & gmask;
      default: xfer_data = 8'd0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = cfg;
      4'd1:    reg_rdata = {7'd0, ready, 7'd0, swcs, 6'd0, dev, 7'd0, busy};
      4'd2:    reg_rdata = cmd;
      4'd3:    reg_rdata = adr;
      4'd4, 4'd5, 4'd6, 4'd7:   reg_rdata = dout[reg_addr[1:0]];
      4'd8, 4'd9, 4'd10, 4'd11: reg_rdata = din[reg_addr[1:0]];
      default: reg_rdata = 32'd0;
    endcase
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_n[k] = !(cs_act && (int'(cs_sel) == k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cfg    <= 32'h0000_0400;
      cmd    <= 32'h0000_000B;
      adr    <= 32'd0;
      dev    <= 2'd0;
      swcs   <= 1'b1;
      ready  <= 1'b0;
      busy   <= 1'b0;
      cs_act <= 1'b0;
      cs_sel <= 2'd0;
      cnt    <= 6'd0;
      grp    <= 3'd0;
      for (int i = 0; i < 4; i++) begin
        dout[i] <= 32'd0;
        din[i]  <= 32'd0;
      end
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          4'd0: cfg <= reg_wdata;
          4'd1: begin
            dev  <= reg_wdata[9:8];
            swcs <= reg_wdata[16];
            if (reg_wdata[24]) ready <= 1'b0;
            if (reg_wdata[0]) begin
              busy   <= 1'b1;
              phase  <= PH_OPC;
              cnt    <= 6'd0;
              grp    <= 3'd0;
              cs_sel <= reg_wdata[9:8];
              cs_act <= reg_wdata[16] && (int'(reg_wdata[9:8]) < NUM_CS);
            end
          end
          4'd2: cmd <= reg_wdata;
          4'd3: adr <= reg_wdata;
          4'd4, 4'd5, 4'd6, 4'd7: dout[reg_addr[1:0]] <= reg_wdata;
          default: ;
        endcase
      end
      if (in_xfer && ph_done) begin
        cnt   <= 6'd0;
        grp   <= 3'd0;
        phase <= phase_t'(phase + 3'd1);
      end else if (take) begin
        if (phase == PH_DUM && grp != glast) begin
          grp <= grp + 3'd1;
        end else begin
          grp <= 3'd0;
          cnt <= cnt + 6'd1;
        end
        if (phase == PH_RD && cnt[5:4] == 2'd0)
          din[cnt[3:2]][{cnt[1:0], 3'b000} +: 8] <= xfer_rdata;
      end
      if (phase == PH_END) begin
        busy   <= 1'b0;
        ready  <= 1'b1;
        cs_act <= 1'b0;
        phase  <= PH_IDLE;
      end
    end
  end

  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> busy); // R7
  AST_END_READY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ready); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_data) && $stable(xfer_bits)); // R2
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> &cs_n); // R8
  AST_BAD_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (int'(dev) >= NUM_CS) |-> &cs_n); // R9

endmodule

// File: tb/test_spi_cmd_sequencer.sv
module test_spi_cmd_sequencer;
  localparam int NCS = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, reg_wr, xfer_req, xfer_ack;
  logic [3:0]     reg_addr, xfer_bits;
  logic [31:0]    reg_wdata, reg_rdata;
  logic [7:0]     xfer_data, xfer_rdata;
  logic [NCS-1:0] cs_n;

  spi_cmd_sequencer #(.NUM_CS(NCS)) i_spi_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .xfer_data(xfer_data), .xfer_bits(xfer_bits), .xfer_ack(xfer_ack),
    .xfer_rdata(xfer_rdata), .cs_n(cs_n));

  int errors = 0, checks = 0, ne = 0, ng = 0, rstart = 0;
  logic [7:0]     ed [256];
  logic [3:0]     eb [256];
  logic [7:0]     gd [256];
  logic [3:0]     gb [256];
  logic [NCS-1:0] gc [256];
  logic [31:0]    dw [4];
  logic [31:0]    edin [4];
  logic [31:0]    cur_cmd, cur_adr;
  bit             finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] d, input logic [3:0] b);
    ed[ne] = d; eb[ne] = b; ne++;
  endtask

  task automatic set_data(input logic [31:0] c, input logic [31:0] a,
                          input logic [31:0] d0, input logic [31:0] d1,
                          input logic [31:0] d2, input logic [31:0] d3);
    cur_cmd = c; cur_adr = a; dw[0] = d0; dw[1] = d1; dw[2] = d2; dw[3] = d3;
    wr(2, c); wr(3, a);
    for (int i = 0; i < 4; i++) wr(4'(4 + i), dw[i]);
  endtask

  task automatic model(input logic [31:0] cfg);
    int a, bw;
    logic [7:0] src, m;
    ne = 0;
    if (cfg[10]) push(cur_cmd[7:0], 4'd8);
    a = int'(cfg[13:11]);
    if (a <= 4) for (int k = a - 1; k >= 0; k--) push(cur_adr[8*k +: 8], 4'd8);
    for (int i = 0; i < int'(cfg[20:16]); i++) begin
      int w = (i < 16) ? i / 4 : 3;
      push(dw[w][8*(i%4) +: 8], 4'd8);
    end
    bw = 1 << cfg[7:6];
    m = 8'((1 << bw) - 1);
    for (int b = 0; b < int'(cfg[23:21]); b++) begin
      src = (b == 0) ? cur_cmd[15:8] : (b == 1) ? cur_cmd[23:16] : cur_cmd[31:24];
      for (int j = 0; j < 8; j += bw) push((src >> j) & m, 4'(bw));
    end
    rstart = ne;
    for (int i = 0; i < int'(cfg[28:24]); i++) begin
      push(8'd0, 4'd8);
      if (i < 16) edin[i/4][8*(i%4) +: 8] = 8'(8'h30 + rstart + i);
    end
  endtask

  task automatic serve();
    ng = 0; reg_addr = 4'd1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk); #1;
      xfer_ack = 1'b0;
      if (xfer_req) begin
        gd[ng] = xfer_data; gb[ng] = xfer_bits; gc[ng] = cs_n;
        xfer_rdata = 8'(8'h30 + ng);
        xfer_ack = 1'b1;
        ng++;
      end else if (!reg_rdata[0]) break;
    end
    xfer_ack = 1'b0;
  endtask

  task automatic run(input string tag, input logic [31:0] cfg,
                     input logic [31:0] cts, input bit busy_writes);
    logic [31:0] v;
    logic [NCS-1:0] ecs;
    ecs = (cts[16] && int'(cts[9:8]) < NCS) ? ~(NCS'(1) << cts[9:8]) : '1;
    wr(0, cfg);
    model(cfg);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = cts;
    @(negedge clk); reg_wr = 1'b0; #1;
    chk({tag, " R7 execute reads 1 while running"}, 32'(reg_rdata[0]), 32'd1);
    if (cts[24]) chk({tag, " R7 ready cleared by starting write"}, 32'(reg_rdata[24]), 32'd0);
    if (busy_writes) begin
      wr(2, 32'hFFFF_FFFF);
      wr(0, 32'h0000_0000);
    end
    serve();
    chk({tag, " R2 transfer count"}, 32'(ng), 32'(ne));
    for (int i = 0; i < ng && i < ne; i++) begin
      chk($sformatf("%s R2 R5 width of item %0d", tag, i), 32'(gb[i]), 32'(eb[i]));
      if (i < rstart)
        chk($sformatf("%s R2 R3 R4 R5 data of item %0d", tag, i), 32'(gd[i]), 32'(ed[i]));
      chk($sformatf("%s R8 R9 chip select at item %0d", tag, i), 32'(gc[i]), 32'(ecs));
    end
    rd(1, v);
    chk({tag, " R7 ready set at end"}, 32'(v[24]), 32'd1);
    chk({tag, " R7 execute cleared at end"}, 32'(v[0]), 32'd0);
    chk({tag, " R8 chip selects released"}, 32'(cs_n), 32'(NCS'('1)));
    for (int w = 0; w < 4; w++) begin
      rd(4'(8 + w), v);
      chk($sformatf("%s R6 data-in word %0d", tag, w), v, edin[w]);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v, e;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      e = (a == 0) ? 32'h400 : (a == 1) ? 32'h10000 : (a == 2) ? 32'hB : 32'd0;
      chk($sformatf("R1 reset value of register %0d", a), v, e);
    end
    chk("R1 chip selects high", 32'(cs_n), 32'(NCS'('1)));
    chk("R1 no request", 32'(xfer_req), 32'd0);
  endtask

  task automatic t_full();
    set_data(32'hC3B2_A19F, 32'h1234_5678, 32'h1122_3344, 32'h5566_7788,
             32'h99AA_BBCC, 32'hDDEE_FF00);
    run("full", (32'd1 << 10) | (32'd3 << 11) | (32'd5 << 16) | (32'd2 << 21) |
                (32'd1 << 6) | (32'd6 << 24), 32'h0001_0101, 1'b0);
  endtask

  task automatic t_long();
    set_data(32'h8D4E_7B21, 32'hA5C3_0F96, 32'h0403_0201, 32'h0807_0605,
             32'h0C0B_0A09, 32'h100F_0E0D);
    run("long R4 R5 R6", (32'd4 << 11) | (32'd18 << 16) | (32'd3 << 21) | (32'd18 << 24),
        32'h0001_0201, 1'b0);
  endtask

  task automatic t_nocs();
    run("no-swcs R8", (32'd1 << 10) | (32'd2 << 11) | (32'd1 << 21) | (32'd3 << 6),
        32'h0000_0001, 1'b0);
    run("bad-cs R9", (32'd1 << 11) | (32'd4 << 21) | (32'd2 << 6) | (32'd1 << 24),
        32'h0001_0301, 1'b0);
  endtask

  task automatic t_addr7();
    run("addr7 R3", (32'd7 << 11) | (32'd1 << 16), 32'h0001_0001, 1'b0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    set_data(32'h0000_005A, 32'd0, dw[0], dw[1], dw[2], dw[3]);
    run("busy-write R10", 32'h0000_0400, 32'h0001_0001, 1'b1);
    rd(2, v);
    chk("R10 opcode word unchanged by busy write", v, 32'h0000_005A);
    rd(0, v);
    chk("R10 config unchanged by busy write", v, 32'h0000_0400);
    wr(8, 32'hDEAD_BEEF);
    rd(8, v);
    chk("R10 data-in write ignored", v, edin[0]);
  endtask

  task automatic t_ready();
    logic [31:0] v;
    run("clear+start R7", (32'd1 << 10) | (32'd2 << 24), 32'h0101_0001, 1'b0);
    wr(1, 32'h0100_0000);
    rd(1, v);
    chk("R7 ready cleared by write of 1", v, 32'h0000_0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = 32'd0;
    xfer_ack = 1'b0; xfer_rdata = 8'd0;
    cur_cmd = 32'hB; cur_adr = 32'd0;
    for (int i = 0; i < 4; i++) begin dw[i] = 32'd0; edin[i] = 32'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_long();
    t_nocs();
    t_addr7();
    t_ignore();
    t_ready();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule